// File: doc/BRIEF.md
# Four-Function Add/Subtract/NAND/NOR Unit

This block is a small arithmetic/logic unit of parameterised width. Two operands enter together with a two-bit operation code: a mode bit (`mode_arith`) and a select bit (`fn_sel`). The code picks one of four functions: addition, subtraction, bitwise NAND or bitwise NOR. Every bit position holds an extender cell. The cell shapes the two addend bits of a shared ripple-carry adder.

In arithmetic mode the first addend is the operand bit `a` unchanged. The second addend is either `b` or its inverse. The adder carry-in is set only for subtraction, so subtraction forms `A + ~B + 1`. In logic mode the cell places NAND(a,b) or NOR(a,b) on the first addend and zero on the second. With a carry-in of zero, the adder passes the logic value through and produces no carry.

The sum and carry-out are registered, with one cycle of latency. The carry-out is reported raw, so in subtraction a carry-out of 1 means the operation did not borrow. The output register resets to zero when the active-low reset is low. The only transition is capture on every rising clock edge.

Top module: `alu4f_top`

## Requirements
- R1: While `rst_n` is low, `result` and `carry_out` are 0.
- R2: The operation code `{mode_arith, fn_sel}` decodes as follows: 2'b10 is add, 2'b11 is subtract, 2'b00 is NAND and 2'b01 is NOR.
- R3: Add: `{carry_out, result}` equals A + B as an unsigned (WIDTH+1)-bit sum.
- R4: Subtract: `result` equals (A − B) mod 2^WIDTH, and `carry_out` is 1 exactly when A ≥ B unsigned (no borrow).
- R5: NAND: `result` equals the bitwise ~(A & B).
- R6: NOR: `result` equals the bitwise ~(A | B).
- R7: In either logic operation, `carry_out` is 0.
- R8: The outputs after a rising edge reflect the operands and code present at that edge, so there is exactly one cycle of latency. The operation may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| mode_arith | input | 1 | 1 = arithmetic, 0 = logic |
| fn_sel | input | 1 | Function select within the mode |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered adder carry-out |

## Verification
The sum bits and the carry-out of one operation are produced in the same cycle. In subtraction both must agree on the borrow, so the bench targets equal operands, A one below B, zero minus all-ones and all-ones minus zero. In each case it compares the full (WIDTH+1)-bit value against a bench-side model. The operation code also changes every cycle between random operand pairs. A NOR that immediately follows a carrying add therefore shows whether a stale carry leaks into a logic result.

// File: rtl/alu4f_pkg.sv
package alu4f_pkg;

    typedef enum logic [1:0] {
        OP_NAND = 2'b00,
        OP_NOR  = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } alu_op_e;

    function automatic alu_op_e decode_op(input logic arith, input logic sel);
        return alu_op_e'({arith, sel});
    endfunction

endpackage

// File: rtl/alu4f_ext_bit.sv
// Per-bit extender: shapes both adder inputs from a, b and the operation code.
module alu4f_ext_bit (
    input  logic a,
    input  logic b,
    input  logic arith,
    input  logic sel,
    output logic x,
    output logic y
);
    always_comb begin
        // second addend: b, ~b, or 0 in logic mode
        y = (arith & ~sel & b) | (arith & sel & ~b);
        // first addend: a, or the logic function in logic mode
        x = (arith & a)
          | (~arith & ~sel & ~(a & b))
          | (~arith &  sel & ~(a | b));
    end
endmodule

// File: rtl/alu4f_ripple.sv
module alu4f_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]     = x[i] ^ y[i] ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/alu4f_top.sv
module alu4f_top
    import alu4f_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             mode_arith,
    input  logic             fn_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int SUM_W = WIDTH + 1;

    alu_op_e          op;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;

    assign op = decode_op(mode_arith, fn_sel);

    for (genvar i = 0; i < WIDTH; i++) begin : g_ext
        alu4f_ext_bit u_ext (
            .a     (op_a[i]),
            .b     (op_b[i]),
            .arith (mode_arith),
            .sel   (fn_sel),
            .x     (add_x[i]),
            .y     (add_y[i])
        );
    end

    // carry-in is set only for subtraction
    always_comb begin
        unique case (op)
            OP_SUB:  add_cin = 1'b1;
            OP_ADD:  add_cin = 1'b0;
            OP_NAND: add_cin = 1'b0;
            OP_NOR:  add_cin = 1'b0;
            default: add_cin = 1'b0;
        endcase
    end

    alu4f_ripple #(.WIDTH(WIDTH)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            result    <= add_sum;
            carry_out <= add_cout;
        end
    end

    // R3
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_arith && !fn_sel) |=>
        ({carry_out, result} == SUM_W'({1'b0, $past(op_a)}) + SUM_W'({1'b0, $past(op_b)})));

    // R4
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_arith && fn_sel) |=>
        (result == WIDTH'($past(op_a) - $past(op_b))) &&
        (carry_out == ($past(op_a) >= $past(op_b))));

    // R5
    nand_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_arith && !fn_sel) |=> (result == ~($past(op_a) & $past(op_b))));

    // R6
    nor_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_arith && fn_sel) |=> (result == ~($past(op_a) | $past(op_b))));

    // R7
    logic_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_arith |=> !carry_out);
endmodule

// File: tb/alu4f_top_test.sv
module alu4f_top_test;
    localparam int W = 8;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         mode_arith = 1'b0;
    logic         fn_sel = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    alu4f_top #(.WIDTH(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a       (op_a),
        .op_b       (op_b),
        .mode_arith (mode_arith),
        .fn_sel     (fn_sel),
        .result     (result),
        .carry_out  (carry_out)
    );

    // R2: {1,0}=add {1,1}=sub {0,0}=nand {0,1}=nor
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic m, input logic s);
        logic [W:0] r;
        case ({m, s})
            2'b10:   r = {1'b0, a} + {1'b0, b};
            2'b11:   r = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
            2'b00:   r = {1'b0, ~(a & b)};
            default: r = {1'b0, ~(a | b)};
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic m, input logic s);
        case ({m, s})
            2'b10:   return "R3";
            2'b11:   return "R4";
            2'b00:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge, sample at the next negedge (R8)
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic m, input logic s);
        logic [W:0] exp;
        op_a = a; op_b = b; mode_arith = m; fn_sel = s;
        exp = model(a, b, m, s);
        @(posedge clk);
        @(negedge clk);
        check(req_of(m, s), {carry_out, result}, exp);
        if (!m) check("R7", {W'(0), carry_out}, '0);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state with an active add on the inputs
        op_a = ONES; op_b = ONES; mode_arith = 1'b1; fn_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {carry_out, result}, '0);
        rst_n = 1'b1;

        // corners
        run_op('0, '0, 1'b1, 1'b0);
        run_op(ONES, ONES, 1'b1, 1'b0);
        run_op(ONES, W'(1), 1'b1, 1'b0);
        run_op(W'(37), W'(37), 1'b1, 1'b1);
        run_op(W'(36), W'(37), 1'b1, 1'b1);
        run_op('0, ONES, 1'b1, 1'b1);
        run_op(ONES, '0, 1'b1, 1'b1);
        run_op('0, '0, 1'b1, 1'b1);
        run_op(ONES, ONES, 1'b0, 1'b0);
        run_op('0, '0, 1'b0, 1'b0);
        run_op(ONES, '0, 1'b0, 1'b1);
        run_op('0, '0, 1'b0, 1'b1);
        // R8: carrying add immediately followed by a logic op
        run_op(ONES, ONES, 1'b1, 1'b0);
        run_op(W'(8'h5A), W'(8'hA5), 1'b0, 1'b1);
        run_op(W'(8'h80), W'(8'h80), 1'b1, 1'b0);
        run_op(W'(8'h0F), W'(8'h3C), 1'b0, 1'b0);

        // random mix, operation changes every cycle
        for (int i = 0; i < 400; i++) begin
            logic [1:0] code;
            code = 2'($urandom);
            run_op(W'($urandom), W'($urandom), code[1], code[0]);
        end

        // R1: reset asserted mid-run
        rst_n = 1'b0;
        op_a = ONES; op_b = W'(1); mode_arith = 1'b1; fn_sel = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", {carry_out, result}, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule